// File: doc/BRIEF.md
# AXI 4 KB Page Burst Splitter

This block sits between an upstream burst source and an AXI4 address channel (read or write). It accepts one burst request at a time, made up of a start address, a beat count and a beat size, and issues one or two AXI burst commands so that no issued burst runs past a 4096-byte page edge. A request that fits inside its page leaves as a single command. A request that runs past the edge is cut in two. The head command covers the bytes that remain in the current page. The tail command starts at the base of the next page and carries the remaining beats.

Each command carries an address, an AXI length (beats minus one), the beat size, a split flag that marks both halves of a cut request, and a last flag that marks the final command of a request. The tail command is presented only after the head command has completed its valid/ready handshake. A parameter selects a single-transfer variant. In that variant the splitting logic is not built, every command has length zero, and the beat count is ignored.

Top module: `axi_page_splitter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_valid` is 0 and `req_ready` is 1.
- R2: A request whose bytes (beats << size) fit in the page remainder (4096 − addr[11:0]) produces one command with the request address, `cmd_len` = beats − 1, `cmd_split` = 0 and `cmd_last` = 1.
- R3: A request that ends exactly on a page edge is not split. It produces one command as in R2.
- R4: A request that runs past the page edge produces a head command first. The head has the request address, `cmd_len` = (4096 − addr[11:0]) / bytes-per-beat − 1, `cmd_split` = 1 and `cmd_last` = 0.
- R5: The tail command follows the head. It has address {addr[ADDR_W-1:12] + 1, 12'h000}, `cmd_len` = beats − head beats − 1, `cmd_split` = 1 and `cmd_last` = 1.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields stay unchanged in the next cycle. The tail appears only after the head's handshake.
- R7: A request is taken on the cycle where `req_valid` and `req_ready` are both 1. `cmd_valid` is 1 on the next cycle, and `req_ready` stays 0 while any command of the request is still pending.
- R8: No issued command crosses a page edge: cmd_addr[11:0] + ((cmd_len + 1) << cmd_size) ≤ 4096.
- R9: Every command carries the request's beat size unchanged in `cmd_size` (log2 of bytes per beat).
- R10: With `BURST_EN` = 0, every request produces exactly one command with the request address, `cmd_len` = 0, `cmd_split` = 0 and `cmd_last` = 1, whatever the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Splitter can take a request |
| req_addr | input | ADDR_W | Start byte address, aligned to the beat size |
| req_beats | input | BEAT_W | Beat count, 1 to MAX_BEATS |
| req_size | input | 3 | log2 of bytes per beat |
| cmd_valid | output | 1 | AXI address command valid |
| cmd_ready | input | 1 | AXI address channel ready |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_len | output | LEN_W | Command length, beats minus one |
| cmd_size | output | 3 | Command beat size |
| cmd_split | output | 1 | Command is one half of a split request |
| cmd_last | output | 1 | Final command of the request |

## Verification
The checker assumes that every request is legal. The beat count is between 1 and MAX_BEATS, `req_size` does not exceed log2(DATA_BYTES), the address is aligned to the beat size, and MAX_BEATS × DATA_BYTES is at most one page. Under these assumptions a request never needs more than two commands. The bench keeps to these limits by construction. It draws beat counts modulo MAX_BEATS plus one, caps the size at 3 for an 8-byte bus, and masks the low address bits to the beat size. It also aims many start offsets close to the page edge, so that splits, exact-edge endings and one-beat heads all occur under random `cmd_ready` back-pressure.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HEAD = 2'd1,
    ST_TAIL = 2'd2
  } bsplit_state_e;

  // bytes left from a page offset up to the next page edge
  function automatic int unsigned page_room(input int unsigned offs,
                                            input int unsigned page);
    return page - offs;
  endfunction

  // total bytes moved by a burst
  function automatic int unsigned span_bytes(input int unsigned beats,
                                             input int unsigned size);
    return beats << size;
  endfunction

  // whole beats that fit into a number of bytes
  function automatic int unsigned beats_in(input int unsigned bytes,
                                           input int unsigned size);
    return bytes >> size;
  endfunction

endpackage

// File: rtl/bsplit_calc.sv
module bsplit_calc #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_W     = 9,
  parameter int PAGE_W     = 12,
  parameter int PAGE_BYTES = 4096,
  parameter bit BURST_EN   = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] beats,
  input  logic [2:0]        size,
  output logic              crosses,
  output logic [BEAT_W-1:0] head_beats,
  output logic [BEAT_W-1:0] tail_beats,
  output logic [ADDR_W-1:0] tail_addr
);
  import bsplit_pkg::*;

  localparam int HI_W = ADDR_W - PAGE_W;

  logic [HI_W-1:0] next_page;
  assign next_page = addr[ADDR_W-1:PAGE_W] + HI_W'(1);
  assign tail_addr = {next_page, PAGE_W'(0)};

  generate
    if (BURST_EN) begin : g_burst
      int unsigned room;
      int unsigned span;
      int unsigned fit;
      always_comb begin
        room       = page_room(32'(addr[PAGE_W-1:0]), PAGE_BYTES);
        span       = span_bytes(32'(beats), 32'(size));
        fit        = beats_in(room, 32'(size));
        crosses    = span > room;
        head_beats = crosses ? BEAT_W'(fit) : beats;
        tail_beats = crosses ? BEAT_W'(32'(beats) - fit) : BEAT_W'(0);
      end
    end else begin : g_single
      assign crosses    = 1'b0;
      assign head_beats = BEAT_W'(1);
      assign tail_beats = BEAT_W'(0);
    end
  endgenerate

endmodule

// File: rtl/bsplit_seq.sv
module bsplit_seq #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 9,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_size,
  input  logic              crosses,
  input  logic [BEAT_W-1:0] head_beats,
  input  logic [BEAT_W-1:0] tail_beats,
  input  logic [ADDR_W-1:0] tail_addr,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [2:0]        cmd_size,
  output logic              cmd_split,
  output logic              cmd_last,
  output logic              req_accept,
  output logic              cmd_fire,
  output logic              tail_launch
);
  import bsplit_pkg::*;

  bsplit_state_e    state_q;
  logic [ADDR_W-1:0] addr_q, tail_addr_q;
  logic [BEAT_W-1:0] beats_q, tail_beats_q;
  logic [2:0]        size_q;
  logic              split_q, last_q;

  assign req_ready   = (state_q == ST_IDLE);
  assign cmd_valid   = (state_q != ST_IDLE);
  assign req_accept  = req_valid && req_ready;
  assign cmd_fire    = cmd_valid && cmd_ready;
  assign tail_launch = cmd_fire && (state_q == ST_HEAD) && !last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      addr_q       <= '0;
      tail_addr_q  <= '0;
      beats_q      <= '0;
      tail_beats_q <= '0;
      size_q       <= '0;
      split_q      <= 1'b0;
      last_q       <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_accept) begin
          state_q      <= ST_HEAD;
          addr_q       <= req_addr;
          beats_q      <= head_beats;
          size_q       <= req_size;
          split_q      <= crosses;
          last_q       <= !crosses;
          tail_addr_q  <= tail_addr;
          tail_beats_q <= tail_beats;
        end
        ST_HEAD: if (tail_launch) begin
          state_q <= ST_TAIL;
          addr_q  <= tail_addr_q;
          beats_q <= tail_beats_q;
          last_q  <= 1'b1;
        end else if (cmd_fire) begin
          state_q <= ST_IDLE;
        end
        ST_TAIL: if (cmd_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_addr  = addr_q;
  assign cmd_len   = LEN_W'(beats_q - BEAT_W'(1));
  assign cmd_size  = size_q;
  assign cmd_split = split_q;
  assign cmd_last  = last_q;

endmodule

// File: rtl/axi_page_splitter.sv
module axi_page_splitter #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8,
  parameter int MAX_BEATS  = 256,
  parameter int PAGE_BYTES = 4096,
  parameter bit BURST_EN   = 1'b1,
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1),
  localparam int LEN_W     = $clog2(MAX_BEATS),
  localparam int PAGE_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic [2:0]        req_size,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic [2:0]        cmd_size,
  output logic              cmd_split,
  output logic              cmd_last
);

  logic              crosses;
  logic [BEAT_W-1:0] head_beats, tail_beats;
  logic [ADDR_W-1:0] tail_addr;
  logic              req_accept, cmd_fire, tail_launch;

  bsplit_calc #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .PAGE_W(PAGE_W),
    .PAGE_BYTES(PAGE_BYTES), .BURST_EN(BURST_EN)
  ) u_calc (
    .addr(req_addr), .beats(req_beats), .size(req_size),
    .crosses(crosses), .head_beats(head_beats),
    .tail_beats(tail_beats), .tail_addr(tail_addr)
  );

  bsplit_seq #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .LEN_W(LEN_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .crosses(crosses), .head_beats(head_beats),
    .tail_beats(tail_beats), .tail_addr(tail_addr),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
    .cmd_split(cmd_split), .cmd_last(cmd_last),
    .req_accept(req_accept), .cmd_fire(cmd_fire),
    .tail_launch(tail_launch)
  );

endmodule

// File: rtl/bsplit_checker.sv
module bsplit_checker #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int PAGE_W     = 12,
  parameter int PAGE_BYTES = 4096,
  parameter bit BURST_EN   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              req_accept,
  input logic              cmd_fire,
  input logic              tail_launch,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic [2:0]        cmd_size,
  input logic              cmd_split,
  input logic              cmd_last
);
  int unsigned cmd_end;
  assign cmd_end = 32'(cmd_addr[PAGE_W-1:0]) + ((32'(cmd_len) + 1) << cmd_size);

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !cmd_valid && req_ready); // R1
  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (!rst_n)
    req_accept |=> cmd_valid && !req_ready); // R7
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)
      && $stable(cmd_split) && $stable(cmd_last)); // R6
  AST_HEAD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_last |-> cmd_split); // R4
  AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tail_launch |=> cmd_valid && cmd_last && cmd_split); // R5
  AST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_end <= PAGE_BYTES); // R8
  AST_SIZE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && !cmd_last |=> $stable(cmd_size)); // R9
  AST_SINGLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !BURST_EN |-> cmd_len == '0 && !cmd_split && cmd_last); // R10

endmodule

bind axi_page_splitter bsplit_checker #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W),
  .PAGE_BYTES(PAGE_BYTES), .BURST_EN(BURST_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .req_accept(req_accept), .cmd_fire(cmd_fire), .tail_launch(tail_launch),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_split(cmd_split),
  .cmd_last(cmd_last)
);

// File: tb/axi_page_splitter_bench.sv
`timescale 1ns/1ps
module axi_page_splitter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, cmd_valid, cmd_ready = 1'b0;
  logic [31:0] req_addr = '0, cmd_addr;
  logic [8:0]  req_beats = 9'd1;
  logic [2:0]  req_size = '0, cmd_size;
  logic [7:0]  cmd_len;
  logic        cmd_split, cmd_last;

  logic        s_valid = 1'b0, s_ready, s_cvalid;
  logic [31:0] s_addr = '0, s_caddr;
  logic [8:0]  s_beats = 9'd1;
  logic [2:0]  s_size = '0, s_csize;
  logic [7:0]  s_clen;
  logic        s_csplit, s_clast;

  axi_page_splitter u_axi_page_splitter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_beats(req_beats), .req_size(req_size),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_split(cmd_split),
    .cmd_last(cmd_last));

  axi_page_splitter #(.BURST_EN(1'b0)) u_axi_page_splitter_single (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_ready(s_ready),
    .req_addr(s_addr), .req_beats(s_beats), .req_size(s_size),
    .cmd_valid(s_cvalid), .cmd_ready(1'b1), .cmd_addr(s_caddr),
    .cmd_len(s_clen), .cmd_size(s_csize), .cmd_split(s_csplit),
    .cmd_last(s_clast));

  typedef struct {
    logic [31:0] a;
    int          len;
    int          sz;
    bit          split;
    bit          last;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit stim_on = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: computes expected commands by division, pushes them, then offers the request
  task automatic send(input logic [31:0] a, input int beats, input int sz);
    int bpb, off, fit;
    exp_t e;
    bpb = 1 << sz;
    off = int'(a % 4096);
    e.sz = sz;
    if (off + beats * bpb > 4096) begin
      fit = (4096 - off) / bpb;
      e.a = a; e.len = fit - 1; e.split = 1; e.last = 0; e.tag = "R4";
      q.push_back(e);
      e.a = (a / 4096 + 1) * 4096; e.len = beats - fit - 1; e.last = 1; e.tag = "R5";
      q.push_back(e);
    end else begin
      e.a = a; e.len = beats - 1; e.split = 0; e.last = 1;
      e.tag = (off + beats * bpb == 4096) ? "R3" : "R2";
      q.push_back(e);
    end
    @(posedge clk); #1;
    req_addr = a; req_beats = 9'(beats); req_size = 3'(sz); req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  // back-pressure
  initial forever begin
    @(posedge clk); #1;
    cmd_ready = stim_on && (($urandom % 4) != 0);
  end

  // monitor / scoreboard
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic [7:0]  prev_len;
  logic        prev_split, prev_last;
  initial forever begin
    @(negedge clk);
    if (rst_n && stim_on) begin
      if (prev_stall) begin
        check(cmd_valid && cmd_addr == prev_addr && cmd_len == prev_len &&
              cmd_split == prev_split && cmd_last == prev_last,
              "R6 hold under stall", {cmd_addr, cmd_len}, {prev_addr, prev_len});
      end
      if (cmd_valid) check(!req_ready, "R7 ready low while pending", req_ready, 0);
      if (cmd_valid && cmd_ready) begin
        exp_t e;
        if (q.size() == 0) begin
          check(0, "R6 unexpected command", cmd_addr, 0);
        end else begin
          e = q.pop_front();
          check(cmd_addr == e.a, {e.tag, " addr"}, cmd_addr, e.a);
          check(int'(cmd_len) == e.len, {e.tag, " len"}, cmd_len, e.len);
          check(cmd_split == e.split && cmd_last == e.last, {e.tag, " flags"},
                {cmd_split, cmd_last}, {e.split, e.last});
          check(int'(cmd_size) == e.sz, "R9 size", cmd_size, e.sz);
          check(int'(cmd_addr % 4096) + ((int'(cmd_len) + 1) << cmd_size) <= 4096,
                "R8 inside page", cmd_addr, 0);
        end
      end
      prev_stall = cmd_valid && !cmd_ready;
      prev_addr = cmd_addr; prev_len = cmd_len;
      prev_split = cmd_split; prev_last = cmd_last;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!cmd_valid && req_ready, "R1 reset state", {cmd_valid, req_ready}, 2'b01);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!cmd_valid && req_ready, "R1 after reset", {cmd_valid, req_ready}, 2'b01);
    stim_on = 1'b1;

    send(32'h0000_1000, 16, 3);      // R2 inside page
    send(32'h0000_2F80, 16, 3);      // R3 ends on edge
    send(32'h0000_3FF8, 4, 3);       // R4/R5 one-beat head
    send(32'h0000_4F00, 256, 2);     // R4/R5 large split
    send(32'h0000_5FFF, 2, 0);       // byte beats across edge
    send(32'h1234_5FC0, 64, 1);      // high address bits carry
    send(32'hFFFF_FFF0, 8, 2);       // address wraps at top
    for (int i = 0; i < 300; i++) begin
      int sz, beats, off;
      logic [31:0] a;
      sz = int'($urandom % 4);
      beats = int'($urandom % 256) + 1;
      if (i % 2 == 0) off = 4096 - ((int'($urandom % 300) + 1) << sz);
      else off = int'($urandom % 4096);
      if (off < 0) off = 0;
      a = {$urandom, 12'h000};
      a[11:0] = 12'(off);
      a = a & ~((32'd1 << sz) - 1);
      send(a, beats, sz);
    end
    while (q.size() != 0 || cmd_valid) @(negedge clk);

    // R10: single-transfer variant ignores the beat count
    @(posedge clk); #1;
    s_addr = 32'h0000_6FF8; s_beats = 9'd40; s_size = 3'd3; s_valid = 1'b1;
    @(posedge clk); #1; s_valid = 1'b0;
    @(negedge clk);
    check(s_cvalid && s_caddr == 32'h0000_6FF8, "R10 single addr", s_caddr, 32'h6FF8);
    check(s_clen == 8'd0 && !s_csplit && s_clast, "R10 single len/flags",
          {s_clen, s_csplit, s_clast}, 10'b1);
    check(s_csize == 3'd3, "R10 single size", s_csize, 3);
    @(negedge clk);
    check(!s_cvalid && s_ready, "R10 no second command", {s_cvalid, s_ready}, 2'b01);

    stim_on = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule